// File: doc/BRIEF.md
# Accumulator ALU with Packed Condition Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator processor. Each valid cycle it takes an operation code, the accumulator, a second operand and the four current condition flags: zero, subtract, half-carry and carry. One clock later it presents a result, a strobe that tells the register file whether to write the accumulator, and the new condition flags packed into the upper nibble of a flag byte.

The operations are add, add with carry, subtract, subtract with borrow, AND, XOR, OR, compare, increment, decrement, four single-bit accumulator rotates (two circular, two through carry), complement, set carry and complement carry. Half-carry always comes from the low nibble. Compare, set-carry and complement-carry change only the flags. Any operation code outside the defined set leaves the accumulator and the flags unchanged.

Top module: `acc_alu`

Operation codes on `opCode`: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 XOR, 6 OR, 7 compare, 8 increment, 9 decrement, 10 rotate-left circular, 11 rotate-right circular, 12 rotate-left through carry, 13 rotate-right through carry, 14 complement, 15 set carry, 16 complement carry. The incoming flag nibble `flagsIn` carries Z at bit 3, N at bit 2, H at bit 1 and C at bit 0.

## Requirements
- R1: The output flag byte holds Z at bit 7, N at bit 6, H at bit 5 and C at bit 4, and bits 3:0 are always zero.
- R2: Add (0) and add-with-carry (1) write the 8-bit sum of accumulator, operand and (for code 1 only) incoming C. C is set on carry out of bit 7. H is set on carry out of bit 3, counting the carry-in. N is cleared. Z is set when the 8-bit sum is zero.
- R3: Subtract (2) and subtract-with-borrow (3) write accumulator minus operand minus (for code 3 only) incoming C. N is set. H is set when the operand's low nibble plus borrow exceeds the accumulator's low nibble. C is set when operand plus borrow exceeds the accumulator. Z is set on a zero 8-bit difference.
- R4: Compare (7) produces the subtract flags of R3 without borrow. It holds `accWrEn` low and shows the unchanged accumulator on `result`.
- R5: AND (4) writes the bitwise AND, sets H, clears N and C, and sets Z on a zero result.
- R6: XOR (5) and OR (6) write their bitwise result, clear N, H and C, and set Z on a zero result.
- R7: Increment (8) and decrement (9) act on the accumulator and keep C. Increment clears N and sets H when the low nibble was 0xF. Decrement sets N and sets H when the low nibble was 0x0. Z is set on a zero result.
- R8: Rotates (10 to 13) shift the accumulator by one bit and clear Z, N and H. C takes the bit shifted out: bit 7 for left, bit 0 for right. Codes 10 and 11 feed that bit into the vacated position. Codes 12 and 13 feed the old C into it.
- R9: Complement (14) writes the inverted accumulator, sets N and H, and keeps Z and C.
- R10: Set carry (15) sets C and complement carry (16) inverts C. Both clear N and H, keep Z, hold `accWrEn` low and show the accumulator on `result`.
- R11: Codes 17 to 31 hold `accWrEn` low, show the accumulator on `result` and pass the incoming flags through unchanged.
- R12: While `rstN` is low, `outValid`, `accWrEn`, `result` and `flagsOut` are all zero.
- R13: The outputs for an operation presented with `opValid` high appear after the next rising edge, with `outValid` high. After a cycle with `opValid` low, `outValid` and `accWrEn` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 5 | Operation code |
| accIn | input | DATA_W (8) | Current accumulator value |
| operandIn | input | DATA_W (8) | Second operand |
| flagsIn | input | 4 | Current flags {Z, N, H, C} |
| result | output | DATA_W (8) | Registered result value |
| accWrEn | output | 1 | Write strobe for the accumulator |
| flagsOut | output | 8 | Registered flag byte {Z, N, H, C, 0000} |
| outValid | output | 1 | Registered outputs are valid |

## Verification
The bench builds the block with the default width of 8 bits. At that width every nibble-boundary and byte-boundary carry and borrow is reachable with random operands, and the expected values are exact byte arithmetic. Random operation codes are drawn over a range that includes some undefined codes, and random incoming flags reach both carry-in states for the carry-using and through-carry operations. Directed vectors pin the edges: 0xFF+1, 0x0F+0 with carry-in, 0x00-1, a borrow that crosses only the nibble, decrement from 0x10, compare of equal values, and each carry-based rotate with either carry.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OPC_W  = 5;
  localparam int FLAG_W = 8;
  localparam int NIB_W  = 4;

  // flag byte bit positions
  localparam int FZ = 7;
  localparam int FN = 6;
  localparam int FH = 5;
  localparam int FC = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_AND  = 5'd4,
    OP_XOR  = 5'd5,
    OP_OR   = 5'd6,
    OP_CMP  = 5'd7,
    OP_INC  = 5'd8,
    OP_DEC  = 5'd9,
    OP_ROLC = 5'd10,
    OP_RORC = 5'd11,
    OP_ROLT = 5'd12,
    OP_RORT = 5'd13,
    OP_INV  = 5'd14,
    OP_CSET = 5'd15,
    OP_CFLP = 5'd16
  } op_e;

  typedef enum logic [2:0] {
    U_ADD, U_SUB, U_AND, U_XOR, U_OR, U_ROT, U_CPL, U_PASS
  } unit_e;

  typedef enum logic [1:0] { Z_RES, Z_KEEP, Z_CLR } zsel_e;
  typedef enum logic [1:0] { N_ZERO, N_ONE, N_KEEP } nsel_e;
  typedef enum logic [1:0] { H_ARITH, H_ZERO, H_ONE, H_KEEP } hsel_e;
  typedef enum logic [2:0] { C_ARITH, C_ZERO, C_ONE, C_KEEP, C_INV, C_ROT } csel_e;

  // strobes from control to datapath
  typedef struct packed {
    unit_e unit;
    logic  useCarry;
    logic  oneAsB;
    logic  rotLeft;
    logic  rotThru;
    logic  writeAcc;
    zsel_e zSel;
    nsel_e nSel;
    hsel_e hSel;
    csel_e cSel;
  } ctl_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opCode,
  output ctl_t             ctl
);

  always_comb begin
    ctl.unit     = U_PASS;
    ctl.useCarry = 1'b0;
    ctl.oneAsB   = 1'b0;
    ctl.rotLeft  = 1'b0;
    ctl.rotThru  = 1'b0;
    ctl.writeAcc = 1'b0;
    ctl.zSel     = Z_KEEP;
    ctl.nSel     = N_KEEP;
    ctl.hSel     = H_KEEP;
    ctl.cSel     = C_KEEP;
    case (opCode)
      OP_ADD, OP_ADC: begin
        ctl.unit     = U_ADD;
        ctl.useCarry = (opCode == OP_ADC);
        ctl.writeAcc = 1'b1;
        ctl.zSel     = Z_RES;
        ctl.nSel     = N_ZERO;
        ctl.hSel     = H_ARITH;
        ctl.cSel     = C_ARITH;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        ctl.unit     = U_SUB;
        ctl.useCarry = (opCode == OP_SBC);
        ctl.writeAcc = (opCode != OP_CMP);
        ctl.zSel     = Z_RES;
        ctl.nSel     = N_ONE;
        ctl.hSel     = H_ARITH;
        ctl.cSel     = C_ARITH;
      end
      OP_AND: begin
        ctl.unit     = U_AND;
        ctl.writeAcc = 1'b1;
        ctl.zSel     = Z_RES;
        ctl.nSel     = N_ZERO;
        ctl.hSel     = H_ONE;
        ctl.cSel     = C_ZERO;
      end
      OP_XOR, OP_OR: begin
        ctl.unit     = (opCode == OP_XOR) ? U_XOR : U_OR;
        ctl.writeAcc = 1'b1;
        ctl.zSel     = Z_RES;
        ctl.nSel     = N_ZERO;
        ctl.hSel     = H_ZERO;
        ctl.cSel     = C_ZERO;
      end
      OP_INC, OP_DEC: begin
        ctl.unit     = (opCode == OP_INC) ? U_ADD : U_SUB;
        ctl.oneAsB   = 1'b1;
        ctl.writeAcc = 1'b1;
        ctl.zSel     = Z_RES;
        ctl.nSel     = (opCode == OP_INC) ? N_ZERO : N_ONE;
        ctl.hSel     = H_ARITH;
        ctl.cSel     = C_KEEP;
      end
      OP_ROLC, OP_RORC, OP_ROLT, OP_RORT: begin
        ctl.unit     = U_ROT;
        ctl.rotLeft  = (opCode == OP_ROLC) || (opCode == OP_ROLT);
        ctl.rotThru  = (opCode == OP_ROLT) || (opCode == OP_RORT);
        ctl.writeAcc = 1'b1;
        ctl.zSel     = Z_CLR;
        ctl.nSel     = N_ZERO;
        ctl.hSel     = H_ZERO;
        ctl.cSel     = C_ROT;
      end
      OP_INV: begin
        ctl.unit     = U_CPL;
        ctl.writeAcc = 1'b1;
        ctl.nSel     = N_ONE;
        ctl.hSel     = H_ONE;
      end
      OP_CSET, OP_CFLP: begin
        ctl.nSel     = N_ZERO;
        ctl.hSel     = H_ZERO;
        ctl.cSel     = (opCode == OP_CSET) ? C_ONE : C_INV;
      end
      default: begin
        // undefined code: pass everything through
      end
    endcase
  end

endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
)(
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic [3:0]        flagsNib,
  output logic [DATA_W-1:0] resOut,
  output logic [FLAG_W-1:0] flagByte
);

  localparam logic [NIB_W:0] NIB_MAX = {1'b0, {NIB_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE_W = {{(DATA_W-1){1'b0}}, 1'b1};

  logic zIn, nIn, hIn, cIn;
  assign zIn = flagsNib[3];
  assign nIn = flagsNib[2];
  assign hIn = flagsNib[1];
  assign cIn = flagsNib[0];

  logic              cinBit;
  logic [DATA_W-1:0] bOp;
  logic [DATA_W:0]   addFull, subFull;
  logic              addHalf, subHalf;
  logic [DATA_W-1:0] rotVal;
  logic              rotOut;
  logic [DATA_W-1:0] unitRes;
  logic              zNew, nNew, hNew, cNew;

  assign cinBit = ctl.useCarry & cIn;
  assign bOp    = ctl.oneAsB ? ONE_W : opnd;

  // adder and subtractor, both one bit wider to expose carry / borrow
  assign addFull = {1'b0, acc} + {1'b0, bOp} + {{DATA_W{1'b0}}, cinBit};
  assign subFull = {1'b0, acc} - {1'b0, bOp} - {{DATA_W{1'b0}}, cinBit};

  // nibble carry and borrow
  assign addHalf = ({1'b0, acc[NIB_W-1:0]} + {1'b0, bOp[NIB_W-1:0]}
                    + {{NIB_W{1'b0}}, cinBit}) > NIB_MAX;
  assign subHalf = {1'b0, acc[NIB_W-1:0]}
                   < ({1'b0, bOp[NIB_W-1:0]} + {{NIB_W{1'b0}}, cinBit});

  // single-bit rotates
  always_comb begin
    if (ctl.rotLeft) begin
      rotOut = acc[DATA_W-1];
      rotVal = {acc[DATA_W-2:0], ctl.rotThru ? cIn : acc[DATA_W-1]};
    end else begin
      rotOut = acc[0];
      rotVal = {ctl.rotThru ? cIn : acc[0], acc[DATA_W-1:1]};
    end
  end

  always_comb begin
    case (ctl.unit)
      U_ADD:   unitRes = addFull[DATA_W-1:0];
      U_SUB:   unitRes = subFull[DATA_W-1:0];
      U_AND:   unitRes = acc & opnd;
      U_XOR:   unitRes = acc ^ opnd;
      U_OR:    unitRes = acc | opnd;
      U_ROT:   unitRes = rotVal;
      U_CPL:   unitRes = ~acc;
      default: unitRes = acc;
    endcase
  end

  assign resOut = ctl.writeAcc ? unitRes : acc;

  always_comb begin
    case (ctl.zSel)
      Z_RES:   zNew = (unitRes == '0);
      Z_CLR:   zNew = 1'b0;
      default: zNew = zIn;
    endcase
    case (ctl.nSel)
      N_ZERO:  nNew = 1'b0;
      N_ONE:   nNew = 1'b1;
      default: nNew = nIn;
    endcase
    case (ctl.hSel)
      H_ARITH: hNew = (ctl.unit == U_SUB) ? subHalf : addHalf;
      H_ZERO:  hNew = 1'b0;
      H_ONE:   hNew = 1'b1;
      default: hNew = hIn;
    endcase
    case (ctl.cSel)
      C_ARITH: cNew = (ctl.unit == U_SUB) ? subFull[DATA_W] : addFull[DATA_W];
      C_ZERO:  cNew = 1'b0;
      C_ONE:   cNew = 1'b1;
      C_INV:   cNew = ~cIn;
      C_ROT:   cNew = rotOut;
      default: cNew = cIn;
    endcase
  end

  always_comb begin
    flagByte     = '0;
    flagByte[FZ] = zNew;
    flagByte[FN] = nNew;
    flagByte[FH] = hNew;
    flagByte[FC] = cNew;
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [4:0]        opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic              accWrEn,
  output logic [7:0]        flagsOut,
  output logic              outValid
);

  ctl_t              ctl;
  logic [DATA_W-1:0] resNext;
  logic [FLAG_W-1:0] flagNext;

  acc_alu_ctrl ctrl_i (
    .opCode (opCode),
    .ctl    (ctl)
  );

  acc_alu_dp #(.DATA_W(DATA_W)) dp_i (
    .ctl      (ctl),
    .acc      (accIn),
    .opnd     (operandIn),
    .flagsNib (flagsIn),
    .resOut   (resNext),
    .flagByte (flagNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      accWrEn  <= 1'b0;
      flagsOut <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= opValid;
      accWrEn  <= opValid & ctl.writeAcc;
      if (opValid) begin
        result   <= resNext;
        flagsOut <= flagNext;
      end
    end
  end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
)(
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [4:0]        opCode,
  input logic [DATA_W-1:0] accIn,
  input logic [DATA_W-1:0] operandIn,
  input logic [3:0]        flagsIn,
  input logic [DATA_W-1:0] result,
  input logic              accWrEn,
  input logic [7:0]        flagsOut,
  input logic              outValid
);

  // R13
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> outValid == $past(opValid));

  // R13
  idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !accWrEn);

  // R4
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMP) |=> (!accWrEn && result == $past(accIn) && flagsOut[FN]));

  // R5
  and_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_AND) |=> (result == $past(accIn & operandIn) && flagsOut[FH]
                                       && !flagsOut[FC] && accWrEn));

  // R7
  incdec_keepc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == OP_INC || opCode == OP_DEC)) |=> flagsOut[FC] == $past(flagsIn[0]));

  // R8
  rot_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode >= OP_ROLC && opCode <= OP_RORT) |=> flagsOut[7:5] == 3'b000);

  // R8
  rolc_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_ROLC) |=> flagsOut[FC] == $past(accIn[DATA_W-1]));

  // R11
  undef_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode > OP_CFLP) |=> (!accWrEn && flagsOut[7:4] == $past(flagsIn)
                                       && result == $past(accIn)));

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opCode    (opCode),
  .accIn     (accIn),
  .operandIn (operandIn),
  .flagsIn   (flagsIn),
  .result    (result),
  .accWrEn   (accWrEn),
  .flagsOut  (flagsOut),
  .outValid  (outValid)
);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;
  localparam int RAND_VECTORS = 3000;

  logic       clk = 1'b0;
  logic       rstN;
  logic       opValid;
  logic [4:0] opCode;
  logic [7:0] accIn, operandIn;
  logic [3:0] flagsIn;
  logic [7:0] result;
  logic       accWrEn;
  logic [7:0] flagsOut;
  logic       outValid;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .opCode    (opCode),
    .accIn     (accIn),
    .operandIn (operandIn),
    .flagsIn   (flagsIn),
    .result    (result),
    .accWrEn   (accWrEn),
    .flagsOut  (flagsOut),
    .outValid  (outValid)
  );

  // expected {accWrEn, result, flag byte} from the requirement text
  function automatic logic [16:0] refModel(input int op, input logic [7:0] a,
                                           input logic [7:0] b, input logic [3:0] f);
    int ai, bi, ci, s;
    logic z, n, h, c, we;
    logic [7:0] r;
    ai = a; bi = b;
    z = f[3]; n = f[2]; h = f[1]; c = f[0];
    r = a; we = 1'b0;
    ci = 0;
    case (op)
      0, 1: begin
        ci = (op == 1 && c) ? 1 : 0;
        s = ai + bi + ci;
        r = s[7:0]; we = 1'b1;
        c = (s > 255); h = ((ai % 16) + (bi % 16) + ci) > 15;
        n = 1'b0; z = (r == 8'h00);
      end
      2, 3, 7: begin
        ci = (op == 3 && c) ? 1 : 0;
        s = ai - bi - ci;
        if (op != 7) begin r = s[7:0]; we = 1'b1; end
        c = (s < 0); h = ((ai % 16) - (bi % 16) - ci) < 0;
        n = 1'b1; z = (s[7:0] == 8'h00);
      end
      4: begin r = a & b; we = 1'b1; z = (r == 0); n = 0; h = 1; c = 0; end
      5: begin r = a ^ b; we = 1'b1; z = (r == 0); n = 0; h = 0; c = 0; end
      6: begin r = a | b; we = 1'b1; z = (r == 0); n = 0; h = 0; c = 0; end
      8: begin
        s = ai + 1; r = s[7:0]; we = 1'b1;
        h = (ai % 16) == 15; n = 0; z = (r == 0);
      end
      9: begin
        s = ai - 1; r = s[7:0]; we = 1'b1;
        h = (ai % 16) == 0; n = 1; z = (r == 0);
      end
      10: begin r = {a[6:0], a[7]}; c = a[7]; z = 0; n = 0; h = 0; we = 1'b1; end
      11: begin r = {a[0], a[7:1]}; c = a[0]; z = 0; n = 0; h = 0; we = 1'b1; end
      12: begin r = {a[6:0], c}; c = a[7]; z = 0; n = 0; h = 0; we = 1'b1; end
      13: begin r = {c, a[7:1]}; c = a[0]; z = 0; n = 0; h = 0; we = 1'b1; end
      14: begin r = ~a; n = 1; h = 1; we = 1'b1; end
      15: begin c = 1; n = 0; h = 0; end
      16: begin c = !c; n = 0; h = 0; end
      default: begin end
    endcase
    return {we, r, z, n, h, c, 4'b0000};
  endfunction

  function automatic string reqTag(input int op);
    case (op)
      0, 1:           return "R2";
      2, 3:           return "R3";
      7:              return "R4";
      4:              return "R5";
      5, 6:           return "R6";
      8, 9:           return "R7";
      10, 11, 12, 13: return "R8";
      14:             return "R9";
      15, 16:         return "R10";
      default:        return "R11";
    endcase
  endfunction

  // drive at a falling edge, sample at the next falling edge (R1, R13)
  task automatic applyVec(input int op, input logic [7:0] a, input logic [7:0] b,
                          input logic [3:0] f);
    logic [16:0] exp;
    opValid = 1'b1; opCode = op[4:0]; accIn = a; operandIn = b; flagsIn = f;
    exp = refModel(op, a, b, f);
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b1 || accWrEn !== exp[16] || result !== exp[15:8]
        || flagsOut !== exp[7:0]) begin
      nFails++;
      $display("FAIL %s R1 R13 op=%0d a=%02h b=%02h f=%h: got v=%b we=%b res=%02h fl=%02h exp v=1 we=%b res=%02h fl=%02h",
               reqTag(op), op, a, b, f, outValid, accWrEn, result, flagsOut,
               exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd7719);
    rstN = 1'b0; opValid = 1'b0; opCode = '0;
    accIn = '0; operandIn = '0; flagsIn = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    nChecks++;
    if (outValid !== 1'b0 || accWrEn !== 1'b0 || result !== 8'h00 || flagsOut !== 8'h00) begin
      nFails++;
      $display("FAIL R12 reset: got v=%b we=%b res=%02h fl=%02h exp all zero",
               outValid, accWrEn, result, flagsOut);
    end
    rstN = 1'b1;
    @(negedge clk);

    // directed corners
    applyVec(0,  8'hFF, 8'h01, 4'h0); // R2 zero, carry, half
    applyVec(1,  8'h0F, 8'h00, 4'h1); // R2 carry-in makes half
    applyVec(1,  8'h0F, 8'h00, 4'h0); // R2 no carry-in
    applyVec(2,  8'h00, 8'h01, 4'h0); // R3 full borrow
    applyVec(3,  8'h10, 8'h0F, 4'h1); // R3 borrow with carry-in
    applyVec(3,  8'h10, 8'h0F, 4'h0); // R3 without
    applyVec(7,  8'h42, 8'h42, 4'h0); // R4 equal compare
    applyVec(4,  8'hF0, 8'h0F, 4'hF); // R5 zero result
    applyVec(5,  8'hAA, 8'hAA, 4'hF); // R6 zero xor
    applyVec(6,  8'h00, 8'h00, 4'h1); // R6 zero or
    applyVec(8,  8'hFF, 8'h00, 4'h1); // R7 wrap keeps C
    applyVec(9,  8'h10, 8'h00, 4'h0); // R7 nibble borrow
    applyVec(9,  8'h01, 8'h00, 4'h1); // R7 zero
    applyVec(12, 8'h80, 8'h00, 4'h8); // R8 through carry, old C=0
    applyVec(13, 8'h01, 8'h00, 4'h1); // R8 through carry, old C=1
    applyVec(10, 8'h81, 8'h00, 4'h8); // R8 circular
    applyVec(11, 8'h00, 8'h00, 4'h8); // R8 Z forced clear
    applyVec(14, 8'h5A, 8'h00, 4'h9); // R9
    applyVec(15, 8'h33, 8'h00, 4'h8); // R10
    applyVec(16, 8'h33, 8'h00, 4'hF); // R10
    applyVec(31, 8'h77, 8'h12, 4'hA); // R11
    applyVec(17, 8'h01, 8'h02, 4'h5); // R11

    // R13 idle cycle
    opValid = 1'b0;
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0 || accWrEn !== 1'b0) begin
      nFails++;
      $display("FAIL R13 idle: got v=%b we=%b exp v=0 we=0", outValid, accWrEn);
    end

    // constrained random
    for (int i = 0; i < RAND_VECTORS; i++) begin
      int op;
      op = $urandom_range(0, 19);
      applyVec(op, 8'($urandom), 8'($urandom), 4'($urandom));
      if (($urandom % 16) == 0) begin
        opValid = 1'b0;
        @(negedge clk);
      end
    end

    opValid = 1'b0;
    @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired after %0d cycles, expected completion earlier", WATCHDOG_CYCLES);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule